// File: doc/BRIEF.md
# Register Rename Unit with Move Elimination

This block turns a group of up to four decoded micro-ops per cycle from architectural register names into physical register tags. A table with one entry per architectural integer register holds the current tag for that register. Each source reads the table. Each destination takes a fresh tag from the pool of unused tags, and the table is updated so that later micro-ops see the new producer. The unit also reports the tag that the destination replaced. When the micro-op retires, that old tag comes back on the retire port.

A micro-op flagged as a register-to-register move is finished at rename. Its destination is pointed at the tag of its first source, no tag is taken from the pool, and the micro-op is marked as needing no execution unit. Tags can therefore be shared. Each tag carries a reference count, and a tag becomes free again only when its count reaches zero. The architectural zero register is never renamed. If the pool cannot cover every allocation in the group, the unit raises stall and changes no state in that cycle.

Top module: `rename_unit`

## Requirements
- R1: After reset, architectural register i maps to tag i for i in 0..31, and tags 32..63 are free.
- R2: Each source specifier in slot s is output as the tag that the table currently holds for it.
- R3: Each non-move destination gets a tag from the pool, taking the lowest-numbered free tags in slot order. Two writes to the same register in one group get different tags.
- R4: A source or destination in a later slot that names a register written by an earlier slot of the same group uses that earlier slot's new tag.
- R5: When several slots of a group write the same register, the table keeps the youngest slot's tag for later cycles.
- R6: A slot with the move flag set and a destination takes its first source's tag as destination tag and allocates nothing. Its no-execution output is 1. This holds even when the pool is empty.
- R7: A non-move micro-op with a destination, such as a load of an immediate constant, allocates a fresh tag, and its no-execution output is 0.
- R8: A specifier with bit 5 set (values 32..63) is the zero register. As a source it reads tag 64. As a destination it allocates nothing, and both its destination and previous tags are 64.
- R9: The previous-tag output of a writing slot is the mapping that the destination had just before this slot, with R4 forwarding included.
- R10: Each retire port entry decrements that tag's reference count. A tag becomes allocatable in the cycle after its count reaches zero, and not while any reference remains.
- R11: If the free tags are fewer than the allocations a group needs, stall is 1, and neither the table nor the pool changes from that group.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 4 | Slot holds a micro-op |
| in_move | input | 4 | Slot is a register-to-register move |
| in_src1 | input | 24 | First source specifier per slot, 6 bits each |
| in_src2 | input | 24 | Second source specifier per slot |
| in_dst_valid | input | 4 | Slot has a destination |
| in_dst | input | 24 | Destination specifier per slot |
| ret_valid | input | 4 | Retire entry valid |
| ret_tag | input | 28 | Tag whose reference is released, 7 bits each |
| stall | output | 1 | Group cannot be renamed this cycle |
| out_psrc1 | output | 28 | Physical tag of first source per slot |
| out_psrc2 | output | 28 | Physical tag of second source per slot |
| out_pdst | output | 28 | New destination tag per slot |
| out_pold | output | 28 | Tag previously mapped to the destination |
| out_no_exec | output | 4 | Slot needs no execution unit |

## Verification
All rename outputs and stall are combinational, so they are due in the same cycle the group is presented. Table, pool and count updates show up only in the following cycle. The driver applies each group one time unit after a rising edge and queues the expected values. The monitor pops and compares them at the falling edge that follows, before the edge that commits state. Effects of a commit or a retire are therefore checked with a later group, in the cycle after it.

// File: rtl/rename_unit.sv
module rename_unit #(
  parameter int SLOTS = 4,
  parameter int NARCH = 32,
  parameter int NPHYS = 64,
  parameter int CNTW  = 7
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [SLOTS-1:0]         in_valid,
  input  logic [SLOTS-1:0]         in_move,
  input  logic [SLOTS*($clog2(NARCH)+1)-1:0] in_src1,
  input  logic [SLOTS*($clog2(NARCH)+1)-1:0] in_src2,
  input  logic [SLOTS-1:0]         in_dst_valid,
  input  logic [SLOTS*($clog2(NARCH)+1)-1:0] in_dst,
  input  logic [SLOTS-1:0]         ret_valid,
  input  logic [SLOTS*($clog2(NPHYS)+1)-1:0] ret_tag,
  output logic                     stall,
  output logic [SLOTS*($clog2(NPHYS)+1)-1:0] out_psrc1,
  output logic [SLOTS*($clog2(NPHYS)+1)-1:0] out_psrc2,
  output logic [SLOTS*($clog2(NPHYS)+1)-1:0] out_pdst,
  output logic [SLOTS*($clog2(NPHYS)+1)-1:0] out_pold,
  output logic [SLOTS-1:0]         out_no_exec
);
  localparam int AW = $clog2(NARCH) + 1;
  localparam int TW = $clog2(NPHYS) + 1;
  localparam logic [TW-1:0] ZTAG = TW'(NPHYS);

  logic [TW-1:0]   rat [NARCH];
  logic [CNTW-1:0] cnt [NPHYS];
  logic [CNTW-1:0] nxt [NPHYS];
  logic [NPHYS-1:0] free;
  logic [AW-1:0] s1a [SLOTS], s2a [SLOTS], da [SLOTS];
  logic [TW-1:0] ps1 [SLOTS], ps2 [SLOTS], pd [SLOTS], po [SLOTS];
  logic [SLOTS-1:0] wr;
  logic [NPHYS-1:0] avail;
  logic short, found, fire;

  for (genvar t = 0; t < NPHYS; t++) begin : g_free
    assign free[t] = (cnt[t] == '0);
  end

  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    assign s1a[s] = in_src1[s*AW +: AW];
    assign s2a[s] = in_src2[s*AW +: AW];
    assign da[s]  = in_dst[s*AW +: AW];
    assign wr[s]  = in_valid[s] & in_dst_valid[s] & ~da[s][AW-1];
    assign out_psrc1[s*TW +: TW] = ps1[s];
    assign out_psrc2[s*TW +: TW] = ps2[s];
    assign out_pdst[s*TW +: TW]  = pd[s];
    assign out_pold[s*TW +: TW]  = po[s];
    assign out_no_exec[s] = in_valid[s] & in_move[s];
  end

  always_comb begin
    avail = free;
    short = 1'b0;
    found = 1'b0;
    for (int s = 0; s < SLOTS; s++) begin
      ps1[s] = s1a[s][AW-1] ? ZTAG : rat[s1a[s][AW-2:0]];
      ps2[s] = s2a[s][AW-1] ? ZTAG : rat[s2a[s][AW-2:0]];
      po[s]  = da[s][AW-1]  ? ZTAG : rat[da[s][AW-2:0]];
      for (int j = 0; j < s; j++) begin
        if (wr[j] && da[j] == s1a[s]) ps1[s] = pd[j];
        if (wr[j] && da[j] == s2a[s]) ps2[s] = pd[j];
        if (wr[j] && da[j] == da[s])  po[s]  = pd[j];
      end
      pd[s] = ZTAG;
      if (wr[s] && in_move[s]) begin
        pd[s] = ps1[s];
      end else if (wr[s]) begin
        found = 1'b0;
        for (int t = 0; t < NPHYS; t++) begin
          if (!found && avail[t]) begin
            pd[s] = TW'(t);
            avail[t] = 1'b0;
            found = 1'b1;
          end
        end
        if (!found) short = 1'b1;
      end
      if (!wr[s]) po[s] = ZTAG;
    end
  end

  assign stall = short;
  assign fire  = ~short;

  always_comb begin
    for (int t = 0; t < NPHYS; t++) begin
      nxt[t] = cnt[t];
      for (int s = 0; s < SLOTS; s++) begin
        if (fire && wr[s] && pd[s] == TW'(t)) nxt[t] = nxt[t] + CNTW'(1);
        if (ret_valid[s] && ret_tag[s*TW +: TW] == TW'(t)) nxt[t] = nxt[t] - CNTW'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NARCH; i++) rat[i] <= TW'(i);
      for (int t = 0; t < NPHYS; t++) cnt[t] <= (t < NARCH) ? CNTW'(1) : '0;
    end else begin
      for (int t = 0; t < NPHYS; t++) cnt[t] <= nxt[t];
      if (fire)
        for (int s = 0; s < SLOTS; s++)
          if (wr[s]) rat[da[s][AW-2:0]] <= pd[s];
    end
  end
endmodule

// File: rtl/rename_unit_chk.sv
module rename_unit_chk #(
  parameter int SLOTS = 4,
  parameter int NARCH = 32,
  parameter int NPHYS = 64
) (
  input logic clk,
  input logic rst_n,
  input logic stall,
  input logic [SLOTS-1:0] in_valid,
  input logic [SLOTS-1:0] in_move,
  input logic [SLOTS-1:0] in_dst_valid,
  input logic [SLOTS*($clog2(NARCH)+1)-1:0] in_src1,
  input logic [SLOTS*($clog2(NARCH)+1)-1:0] in_dst,
  input logic [SLOTS*($clog2(NPHYS)+1)-1:0] out_psrc1,
  input logic [SLOTS*($clog2(NPHYS)+1)-1:0] out_pdst,
  input logic [SLOTS-1:0] out_no_exec,
  input logic [NPHYS-1:0] free
);
  localparam int AW = $clog2(NARCH) + 1;
  localparam int TW = $clog2(NPHYS) + 1;

  AST_STALL_SHORT: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> $countones(free) < SLOTS); // R11

  for (genvar s = 0; s < SLOTS; s++) begin : g_s
    AST_ZERO_SRC: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid[s] && in_src1[s*AW+AW-1]) |-> out_psrc1[s*TW +: TW] == TW'(NPHYS)); // R8
    AST_MOVE_SHARES: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid[s] && in_move[s] && in_dst_valid[s] && !in_dst[s*AW+AW-1])
        |-> (out_pdst[s*TW +: TW] == out_psrc1[s*TW +: TW]) && out_no_exec[s]); // R6
    AST_ALLOC_FREE: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid[s] && !in_move[s] && in_dst_valid[s] && !in_dst[s*AW+AW-1] && !stall)
        |-> !out_pdst[s*TW+TW-1] && free[out_pdst[s*TW +: TW-1]] && !out_no_exec[s]); // R7
    for (genvar k = s + 1; k < SLOTS; k++) begin : g_k
      AST_DISTINCT_TAGS: assert property (@(posedge clk) disable iff (!rst_n)
        (!stall && in_valid[s] && in_valid[k] && !in_move[s] && !in_move[k]
          && in_dst_valid[s] && in_dst_valid[k] && !in_dst[s*AW+AW-1] && !in_dst[k*AW+AW-1])
          |-> out_pdst[s*TW +: TW] != out_pdst[k*TW +: TW]); // R3
    end
  end
endmodule

bind rename_unit rename_unit_chk #(.SLOTS(SLOTS), .NARCH(NARCH), .NPHYS(NPHYS)) u_chk (
  .clk(clk), .rst_n(rst_n), .stall(stall), .in_valid(in_valid), .in_move(in_move),
  .in_dst_valid(in_dst_valid), .in_src1(in_src1), .in_dst(in_dst),
  .out_psrc1(out_psrc1), .out_pdst(out_pdst), .out_no_exec(out_no_exec), .free(free));

// File: tb/rename_unit_test.sv
module rename_unit_test;
  localparam int W = 4, AW = 6, TW = 7, ZR = 32, ZT = 64;

  logic clk = 1'b0;
  always #5 clk = ~clk;
  logic rst_n;
  logic [W-1:0] in_valid, in_move, in_dst_valid, ret_valid;
  logic [W*AW-1:0] in_src1, in_src2, in_dst;
  logic [W*TW-1:0] ret_tag, out_psrc1, out_psrc2, out_pdst, out_pold;
  logic [W-1:0] out_no_exec;
  logic stall;

  rename_unit uut (.clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_move(in_move),
    .in_src1(in_src1), .in_src2(in_src2), .in_dst_valid(in_dst_valid), .in_dst(in_dst),
    .ret_valid(ret_valid), .ret_tag(ret_tag), .stall(stall), .out_psrc1(out_psrc1),
    .out_psrc2(out_psrc2), .out_pdst(out_pdst), .out_pold(out_pold), .out_no_exec(out_no_exec));

  typedef struct {
    string req;
    int st;
    int ps1[W]; int ps2[W]; int pd[W]; int po[W]; int ne[W];
  } exp_t;

  exp_t q[$];
  exp_t e;
  int checks = 0, errors = 0;

  task automatic clr();
    in_valid = '0; in_move = '0; in_dst_valid = '0; ret_valid = '0;
    in_src1 = '0; in_src2 = '0; in_dst = '0; ret_tag = '0;
    e.req = ""; e.st = -1;
    for (int s = 0; s < W; s++) begin
      e.ps1[s] = -1; e.ps2[s] = -1; e.pd[s] = -1; e.po[s] = -1; e.ne[s] = -1;
    end
  endtask

  task automatic slot(int s, int a, int b, int d, bit dv, bit mv);
    in_valid[s] = 1'b1; in_move[s] = mv; in_dst_valid[s] = dv;
    in_src1[s*AW +: AW] = AW'(a); in_src2[s*AW +: AW] = AW'(b); in_dst[s*AW +: AW] = AW'(d);
  endtask

  task automatic ret(int k, int tag);
    ret_valid[k] = 1'b1; ret_tag[k*TW +: TW] = TW'(tag);
  endtask

  task automatic go(string req);
    e.req = req;
    q.push_back(e);
    @(posedge clk); #1;
    clr();
  endtask

  task automatic cmp(string r, string f, int act, int exp);
    if (exp >= 0) begin
      checks++;
      if (act != exp) begin
        errors++;
        $display("FAIL %s %s: got %0d expected %0d", r, f, act, exp);
      end
    end
  endtask

  always @(negedge clk) begin
    exp_t x;
    if (q.size() > 0) begin
      x = q.pop_front();
      cmp(x.req, "stall", int'(stall), x.st);
      for (int s = 0; s < W; s++) begin
        cmp(x.req, $sformatf("psrc1[%0d]", s), int'(out_psrc1[s*TW +: TW]), x.ps1[s]);
        cmp(x.req, $sformatf("psrc2[%0d]", s), int'(out_psrc2[s*TW +: TW]), x.ps2[s]);
        cmp(x.req, $sformatf("pdst[%0d]", s), int'(out_pdst[s*TW +: TW]), x.pd[s]);
        cmp(x.req, $sformatf("pold[%0d]", s), int'(out_pold[s*TW +: TW]), x.po[s]);
        cmp(x.req, $sformatf("no_exec[%0d]", s), int'(out_no_exec[s]), x.ne[s]);
      end
    end
  end

  initial begin
    #2000000;
    errors++;
    $display("FAIL R11 watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    clr();
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 R2 R8: reset mapping, zero register source
    slot(0, 5, ZR, 0, 0, 0); slot(1, 31, 0, 0, 0, 0);
    e.st = 0; e.ps1[0] = 5; e.ps2[0] = ZT; e.ps1[1] = 31; e.ps2[1] = 0;
    go("R1 R2 R8");

    // R3 R4 R7 R9: group with true and write-after-write dependencies
    slot(0, 2, 1, 3, 1, 0); slot(1, 3, 1, 4, 1, 0); slot(2, 5, 1, 3, 1, 0); slot(3, 8, 7, 6, 1, 0);
    e.st = 0;
    e.ps1 = '{2, 32, 5, 8}; e.ps2 = '{1, 1, 1, 7};
    e.pd = '{32, 33, 34, 35}; e.po = '{3, 4, 32, 6}; e.ne = '{0, 0, 0, 0};
    go("R3 R4 R7 R9");

    // R5: youngest write to x3 kept
    slot(0, 3, 4, 0, 0, 0); slot(1, 6, ZR, 0, 0, 0);
    e.ps1[0] = 34; e.ps2[0] = 33; e.ps1[1] = 35;
    go("R5 R2");

    // R6 R7 R8: move, immediate load, zero destination
    slot(0, 2, ZR, 1, 1, 1); slot(1, 1, ZR, 0, 0, 0); slot(2, ZR, ZR, 7, 1, 0); slot(3, 0, 0, ZR, 1, 0);
    e.st = 0;
    e.pd[0] = 2; e.po[0] = 1; e.ne[0] = 1; e.ps1[1] = 2;
    e.pd[2] = 36; e.po[2] = 7; e.ne[2] = 0;
    e.pd[3] = ZT; e.po[3] = ZT; e.ne[3] = 0;
    go("R6 R7 R8 R4");

    // R6 R8 R10: move committed, zero destination took nothing; retire tag 1
    slot(0, 1, ZR, 0, 0, 0); slot(1, 7, ZR, 9, 1, 0);
    ret(0, 1);
    e.ps1[0] = 2; e.ps1[1] = 36; e.pd[1] = 37; e.po[1] = 9;
    go("R6 R8 R10");

    // R10: tag 1 reusable; release one of two references to tag 2
    slot(0, 0, 0, 10, 1, 0);
    ret(0, 2);
    e.pd[0] = 1; e.po[0] = 10;
    go("R10");

    // R10: tag 2 still referenced, not reallocated
    slot(0, 0, 0, 11, 1, 0);
    e.pd[0] = 38; e.po[0] = 11;
    go("R10");

    // R3: drain pool down to one tag
    for (int g = 0; g < 6; g++) begin
      for (int s = 0; s < W; s++) slot(s, 0, 0, 20 + s, 1, 0);
      e.st = 0; e.pd[0] = 39 + 4 * g; e.pd[3] = 42 + 4 * g;
      go("R3");
    end

    // R11: four allocations with one free tag
    slot(0, 12, 0, 12, 1, 0); slot(1, 0, 0, 13, 1, 0); slot(2, 0, 0, 14, 1, 0); slot(3, 0, 0, 15, 1, 0);
    e.st = 1;
    go("R11");

    // R11: nothing changed by the stalled group
    slot(0, 12, ZR, 0, 0, 0); slot(1, 0, 0, 13, 1, 0);
    e.st = 0; e.ps1[0] = 12; e.pd[1] = 63; e.po[1] = 13;
    go("R11");

    // R6 R11: move proceeds with empty pool
    slot(0, 1, ZR, 16, 1, 1);
    e.st = 0; e.ps1[0] = 2; e.pd[0] = 2; e.po[0] = 16; e.ne[0] = 1;
    go("R6 R11");

    @(posedge clk); #1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule